// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Masks

This block is the arithmetic and logic stage of a small accumulator machine. It has no clock. It takes a 4-bit operation code, the accumulator, a second operand and the current carry flag. In the same cycle it returns the result byte, a strobe saying whether the result should be written back, four flag values (zero Z, subtract N, half-carry H, carry C) and a 4-bit mask. The mask says which flags the surrounding flag register must take. Flags whose mask bit is clear keep their previous value.

There are ten operations: add, add with carry, subtract, subtract with borrow, AND, OR, XOR, compare, increment and decrement. Compare sets the flags like a subtraction but never writes the result. Increment and decrement never touch the carry flag.

A separate path packs a four-flag value into a byte for a stack push, and unpacks a popped byte back into flags. This path is independent of the ALU operation.

Top module: `alu8_core`

## Requirements
- R1: Add (op 0) and add-with-carry (op 1) return A+B (plus carry_i for op 1) modulo 256. Z is set when the result is zero and N is 0. H is the carry out of bit 3 and C is the carry out of bit 7. result_we_o is 1.
- R2: Subtract (op 2) and subtract-with-borrow (op 3) return A−B (minus carry_i for op 3) modulo 256. N is 1 and Z is set when the result is zero. H is the borrow from bit 4, and C is set when the subtracted amount exceeds A. result_we_o is 1.
- R3: Compare (op 7) sets Z, N, H and C exactly as subtract (op 2) does, with all four mask bits set. result_we_o is 0.
- R4: AND (op 4) gives H=1 and C=0. OR (op 5) and XOR (op 6) give H=0 and C=0. All three give N=0, set Z from the result and assert result_we_o.
- R5: Increment (op 8) returns A+1 with N=0 and H set on a carry out of bit 3. Decrement (op 9) returns A−1 with N=1 and H set on a borrow from bit 4. Both set Z from the result and return mask 4'b1110, so C is left untouched. The reported C value is 0.
- R6: The packed byte carries Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, with bits 3..0 always zero. Unpacking takes Z, N, H and C from bits 7, 6, 5 and 4 of the incoming byte.
- R7: Flags vectors and the mask use bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C. Ops 0 to 7 return mask 4'b1111.
- R8: Op codes 10 to 15 give result 0, result_we_o 0, flags 0 and mask 0.
- R9: For op 1, H is set when A[3:0]+B[3:0]+carry_i exceeds 15. For op 3, H is set when A[3:0] is less than B[3:0]+carry_i, and C is set when A is less than B+carry_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0 add, 1 add+carry, 2 sub, 3 sub+borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 increment, 9 decrement) |
| acc_i | input | 8 | Accumulator operand A |
| opb_i | input | 8 | Second operand B (ignored by ops 8 and 9) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Operation result |
| result_we_o | output | 1 | Result write strobe |
| flags_o | output | 4 | New flag values {Z,N,H,C} |
| flag_we_o | output | 4 | Per-flag update mask {Z,N,H,C} |
| fpack_i | input | 4 | Flags {Z,N,H,C} to pack |
| fpack_byte_o | output | 8 | Packed flag byte |
| funpack_byte_i | input | 8 | Byte to unpack |
| funpack_o | output | 4 | Unpacked flags {Z,N,H,C} |

## Verification
Every output is combinational, so each result is due zero cycles after its stimulus, with no register on the way. The bench drives a new set of operands just after a rising clock edge and compares all outputs at the following falling edge. That gives the logic half a clock period to settle, and no check ever samples at the same edge where inputs change. The packing path is checked the same way.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam logic [3:0] OP_ADD = 4'd0;
   localparam logic [3:0] OP_ADC = 4'd1;
   localparam logic [3:0] OP_SUB = 4'd2;
   localparam logic [3:0] OP_SBC = 4'd3;
   localparam logic [3:0] OP_AND = 4'd4;
   localparam logic [3:0] OP_OR  = 4'd5;
   localparam logic [3:0] OP_XOR = 4'd6;
   localparam logic [3:0] OP_CMP = 4'd7;
   localparam logic [3:0] OP_INC = 4'd8;
   localparam logic [3:0] OP_DEC = 4'd9;

   localparam int FLAG_W = 4;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flags_t;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2
   } logic_sel_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int WIDTH  = 8,
   parameter int NIB    = 4,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o,
   output logic             half_o
);
   localparam int W1 = WIDTH + 1;
   localparam int N1 = NIB + 1;

   if (NIB >= WIDTH || NIB < 1) begin : g_bad_cfg
      $error("alu8_addsub: NIB must lie between 1 and WIDTH-1");
   end

   logic [WIDTH-1:0] b_eff;
   logic             c0;
   logic             cy_top;
   logic             cy_nib;

   assign b_eff = sub_i ? ~b_i : b_i;
   assign c0    = sub_i ? ~cin_i : cin_i;

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = c0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum_o[i] = a_i[i] ^ b_eff[i] ^ cy[i];
         assign cy[i+1]  = (a_i[i] & b_eff[i]) | (cy[i] & (a_i[i] ^ b_eff[i]));
      end
      assign cy_top = cy[WIDTH];
      assign cy_nib = cy[NIB];
   end else begin : g_behav
      logic [WIDTH:0] full;
      logic [NIB:0]   nib;
      assign full   = {1'b0, a_i} + {1'b0, b_eff} + W1'(c0);
      assign nib    = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + N1'(c0);
      assign sum_o  = full[WIDTH-1:0];
      assign cy_top = full[WIDTH];
      assign cy_nib = nib[NIB];
   end

   // In subtract mode a missing carry out means a borrow happened.
   assign carry_o = sub_i ? ~cy_top : cy_top;
   assign half_o  = sub_i ? ~cy_nib : cy_nib;
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic_sel_e       sel_i,
   output logic [WIDTH-1:0] y_o
);
   always_comb begin
      unique case (sel_i)
         LG_AND:  y_o = a_i & b_i;
         LG_OR:   y_o = a_i | b_i;
         LG_XOR:  y_o = a_i ^ b_i;
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/alu8_flagpack.sv
module alu8_flagpack #(
   parameter int BYTE_W = 8,
   parameter int FW     = 4
) (
   input  logic [FW-1:0]     flags_i,
   output logic [BYTE_W-1:0] byte_o,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [FW-1:0]     flags_o
);
   localparam int PAD_W = BYTE_W - FW;

   if (PAD_W < 1) begin : g_bad_cfg
      $error("alu8_flagpack: byte must be wider than the flag set");
   end

   assign byte_o  = {flags_i, {PAD_W{1'b0}}};
   assign flags_o = byte_i[BYTE_W-1 -: FW];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [3:0]       op_i,
   input  logic [WIDTH-1:0] acc_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] result_o,
   output logic             result_we_o,
   output logic [3:0]       flags_o,
   output logic [3:0]       flag_we_o,
   input  logic [3:0]       fpack_i,
   output logic [7:0]       fpack_byte_o,
   input  logic [7:0]       funpack_byte_i,
   output logic [3:0]       funpack_o
);
   localparam int NIB     = 4;
   localparam int STACK_W = 8;

   if (WIDTH < NIB + 1) begin : g_bad_cfg
      $error("alu8_core: WIDTH too small for a half-carry nibble");
   end

   logic [WIDTH-1:0] as_b;
   logic             as_cin;
   logic             as_sub;
   logic [WIDTH-1:0] as_sum;
   logic             as_carry;
   logic             as_half;
   logic             is_arith;
   logic             is_incdec;
   logic             is_logic;
   logic_sel_e       lg_sel;
   logic [WIDTH-1:0] lg_y;
   logic [WIDTH-1:0] res;
   flags_t           fl;

   always_comb begin
      as_b      = opb_i;
      as_cin    = 1'b0;
      as_sub    = 1'b0;
      is_arith  = 1'b0;
      is_incdec = 1'b0;
      is_logic  = 1'b0;
      lg_sel    = LG_AND;
      case (op_i)
         OP_ADD: is_arith = 1'b1;
         OP_ADC: begin is_arith = 1'b1; as_cin = carry_i; end
         OP_SUB, OP_CMP: begin is_arith = 1'b1; as_sub = 1'b1; end
         OP_SBC: begin is_arith = 1'b1; as_sub = 1'b1; as_cin = carry_i; end
         OP_INC: begin
            is_arith = 1'b1; is_incdec = 1'b1; as_b = '0; as_cin = 1'b1;
         end
         OP_DEC: begin
            is_arith = 1'b1; is_incdec = 1'b1; as_b = '0; as_cin = 1'b1;
            as_sub = 1'b1;
         end
         OP_AND: begin is_logic = 1'b1; lg_sel = LG_AND; end
         OP_OR:  begin is_logic = 1'b1; lg_sel = LG_OR;  end
         OP_XOR: begin is_logic = 1'b1; lg_sel = LG_XOR; end
         default: ;
      endcase
   end

   alu8_addsub #(.WIDTH(WIDTH), .NIB(NIB), .RIPPLE(RIPPLE)) u_addsub (
      .a_i     (acc_i),
      .b_i     (as_b),
      .cin_i   (as_cin),
      .sub_i   (as_sub),
      .sum_o   (as_sum),
      .carry_o (as_carry),
      .half_o  (as_half)
   );

   alu8_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i   (acc_i),
      .b_i   (opb_i),
      .sel_i (lg_sel),
      .y_o   (lg_y)
   );

   always_comb begin
      res = '0;
      if (is_arith)      res = as_sum;
      else if (is_logic) res = lg_y;

      fl = '0;
      if (is_arith || is_logic) begin
         fl.z = (res == '0);
         fl.n = as_sub;
         fl.h = is_arith ? as_half : (op_i == OP_AND);
         fl.c = (is_arith && !is_incdec) ? as_carry : 1'b0;
      end
   end

   assign result_o    = res;
   assign result_we_o = (is_arith || is_logic) && (op_i != OP_CMP);
   assign flags_o     = fl;
   assign flag_we_o   = is_incdec ? 4'b1110 :
                        (is_arith || is_logic) ? 4'b1111 : 4'b0000;

   alu8_flagpack #(.BYTE_W(STACK_W), .FW(FLAG_W)) u_flagpack (
      .flags_i (fpack_i),
      .byte_o  (fpack_byte_o),
      .byte_i  (funpack_byte_i),
      .flags_o (funpack_o)
   );
endmodule

// File: rtl/alu8_core_checker.sv
module alu8_core_checker #(
   parameter int WIDTH = 8
) (
   input logic [3:0]       op_i,
   input logic [WIDTH-1:0] result_o,
   input logic             result_we_o,
   input logic [3:0]       flags_o,
   input logic [3:0]       flag_we_o,
   input logic [7:0]       fpack_byte_o
);
   always_comb begin
      if (result_we_o) begin
         AST_Z_FOLLOWS_RESULT: assert (flags_o[3] == (result_o == '0)); // R1
      end
      if (op_i == 4'd2 || op_i == 4'd3) begin
         AST_SUB_SETS_N: assert (flags_o[2] == 1'b1); // R2
      end
      if (op_i == 4'd7) begin
         AST_CMP_NO_WRITE: assert (!result_we_o && flag_we_o == 4'b1111); // R3
      end
      if (op_i == 4'd4) begin
         AST_AND_HALF_SET: assert (flags_o[1] && !flags_o[0]); // R4
      end
      if (op_i == 4'd8 || op_i == 4'd9) begin
         AST_INCDEC_KEEPS_C: assert (!flag_we_o[0] && result_we_o); // R5
      end
      AST_PACK_LOW_ZERO: assert (fpack_byte_o[3:0] == 4'b0000); // R6
      if (op_i > 4'd9) begin
         AST_UNUSED_SILENT: assert (!result_we_o && flag_we_o == 4'b0000); // R8
      end
   end
endmodule

bind alu8_core alu8_core_checker #(.WIDTH(WIDTH)) u_checker (
   .op_i         (op_i),
   .result_o     (result_o),
   .result_we_o  (result_we_o),
   .flags_o      (flags_o),
   .flag_we_o    (flag_we_o),
   .fpack_byte_o (fpack_byte_o)
);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] op_i = 4'd15;
   logic [7:0] acc_i = 8'h00;
   logic [7:0] opb_i = 8'h00;
   logic       carry_i = 1'b0;
   logic [7:0] result_o;
   logic       result_we_o;
   logic [3:0] flags_o;
   logic [3:0] flag_we_o;
   logic [3:0] fpack_i = 4'h0;
   logic [7:0] fpack_byte_o;
   logic [7:0] funpack_byte_i = 8'h00;
   logic [3:0] funpack_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8_core u_alu8_core (
      .op_i           (op_i),
      .acc_i          (acc_i),
      .opb_i          (opb_i),
      .carry_i        (carry_i),
      .result_o       (result_o),
      .result_we_o    (result_we_o),
      .flags_o        (flags_o),
      .flag_we_o      (flag_we_o),
      .fpack_i        (fpack_i),
      .fpack_byte_o   (fpack_byte_o),
      .funpack_byte_i (funpack_byte_i),
      .funpack_o      (funpack_o)
   );

   // Expected outputs, packed {result, we, flags, mask} = 17 bits
   function automatic logic [16:0] expect_vec(input int op, input int a, input int b, input int c);
      int r = 0; bit we = 0; bit z = 0, n = 0, h = 0, cy = 0; logic [3:0] m = 4'b0000;
      case (op)
         0, 1: begin
            int ci = (op == 1) ? c : 0;
            r = a + b + ci; h = ((a % 16) + (b % 16) + ci) > 15; cy = r > 255;
            we = 1; m = 4'b1111;
         end
         2, 3, 7: begin
            int ci = (op == 3) ? c : 0;
            r = a - b - ci; n = 1; h = (a % 16) < ((b % 16) + ci); cy = a < (b + ci);
            we = (op != 7); m = 4'b1111;
         end
         4: begin r = a & b; h = 1; we = 1; m = 4'b1111; end
         5: begin r = a | b; we = 1; m = 4'b1111; end
         6: begin r = a ^ b; we = 1; m = 4'b1111; end
         8: begin r = a + 1; h = (a % 16) == 15; we = 1; m = 4'b1110; end
         9: begin r = a - 1; n = 1; h = (a % 16) == 0; we = 1; m = 4'b1110; end
         default: ;
      endcase
      r = r & 255;
      if (m != 4'b0000) z = (r == 0);
      return {8'(r), we, z, n, h, cy, m};
   endfunction

   task automatic run_vec(input string tag, input int op, input int a, input int b, input int c);
      logic [16:0] exp_v;
      logic [16:0] got_v;
      @(posedge clk);
      #1;
      op_i = 4'(op); acc_i = 8'(a); opb_i = 8'(b); carry_i = c[0];
      @(negedge clk);
      exp_v = expect_vec(op, a, b, c);
      got_v = {result_o, result_we_o, flags_o, flag_we_o};
      n_tests++;
      if (got_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%02h b=%02h c=%0d: got res=%02h we=%b f=%b m=%b exp res=%02h we=%b f=%b m=%b",
                  tag, op, a, b, c, got_v[16:9], got_v[8], got_v[7:4], got_v[3:0],
                  exp_v[16:9], exp_v[8], exp_v[7:4], exp_v[3:0]);
      end
   endtask

   task automatic t_idle;
      // R8 state seen while held in reset with an unused op code
      @(negedge clk);
      n_tests++;
      if (result_o !== 8'h00 || result_we_o !== 1'b0 || flag_we_o !== 4'b0000) begin
         n_fail++;
         $display("FAIL R8 idle: got res=%02h we=%b m=%b exp 00 0 0000", result_o, result_we_o, flag_we_o);
      end
   endtask

   task automatic t_add;
      run_vec("R1 add", 0, 8'h3A, 8'hC6, 0);   // zero result, both carries
      run_vec("R1 add", 0, 8'h12, 8'h34, 1);   // carry_i ignored
      run_vec("R1 add", 0, 8'h08, 8'h08, 0);   // half only
   endtask

   task automatic t_adc;
      run_vec("R9 adc", 1, 8'h0F, 8'h00, 1);   // half from carry in
      run_vec("R9 adc", 1, 8'hFF, 8'h00, 1);
      run_vec("R1 adc", 1, 8'h20, 8'h10, 0);
   endtask

   task automatic t_sub;
      run_vec("R2 sub", 2, 8'h10, 8'h01, 0);   // half borrow
      run_vec("R2 sub", 2, 8'h05, 8'h05, 1);   // zero, carry_i ignored
      run_vec("R2 sub", 2, 8'h01, 8'h02, 0);   // borrow
   endtask

   task automatic t_sbc;
      run_vec("R9 sbc", 3, 8'h10, 8'h0F, 1);   // B+cin = 16 > low nibble
      run_vec("R9 sbc", 3, 8'h05, 8'h05, 1);   // borrow only from carry in
      run_vec("R2 sbc", 3, 8'h80, 8'h01, 0);
   endtask

   task automatic t_cmp;
      run_vec("R3 cmp", 7, 8'h42, 8'h42, 0);
      run_vec("R3 cmp", 7, 8'h10, 8'h20, 1);
   endtask

   task automatic t_logic;
      run_vec("R4 and", 4, 8'hF0, 8'h0F, 1);
      run_vec("R4 and", 4, 8'hAA, 8'hA5, 0);
      run_vec("R4 or", 5, 8'h00, 8'h00, 1);
      run_vec("R4 xor", 6, 8'h5A, 8'h0F, 0);
      run_vec("R4 xor", 6, 8'h77, 8'h77, 1);
   endtask

   task automatic t_incdec;
      run_vec("R5 inc", 8, 8'hFF, 8'h55, 1);   // wraps to zero, C masked
      run_vec("R5 inc", 8, 8'h0F, 8'h00, 0);
      run_vec("R5 dec", 9, 8'h00, 8'hAA, 1);
      run_vec("R5 dec", 9, 8'h01, 8'h00, 0);
   endtask

   task automatic t_mask;
      // R7 full mask for each of ops 0..7
      for (int op = 0; op < 8; op++) run_vec("R7 mask", op, 8'h96, 8'h69, op % 2);
   endtask

   task automatic t_unused;
      for (int op = 10; op < 16; op++) run_vec("R8 unused", op, 8'hFF, 8'h01, 1);
   endtask

   task automatic t_pack;
      for (int v = 0; v < 16; v++) begin
         @(posedge clk);
         #1;
         fpack_i = 4'(v);
         funpack_byte_i = {4'(15 - v), 4'(v)};
         @(negedge clk);
         n_tests++;
         if (fpack_byte_o !== {4'(v), 4'b0000} || funpack_o !== 4'(15 - v)) begin
            n_fail++;
            $display("FAIL R6 pack v=%0d: got byte=%02h unpack=%h exp byte=%02h unpack=%h",
                     v, fpack_byte_o, funpack_o, {4'(v), 4'b0000}, 4'(15 - v));
         end
      end
   endtask

   initial begin
      t_idle();
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_add();
      t_adc();
      t_sub();
      t_sbc();
      t_cmp();
      t_logic();
      t_incdec();
      t_mask();
      t_unused();
      t_pack();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule